// File: doc/BRIEF.md
# Fractional-N Ratio Source Selector

This block decides, on every reference clock edge, which ratio the fractional-N frequency synthesizer uses. There are two choices. The static choice is a stored ratio applied to the reference clock. The dynamic choice is a ratio tracked from the external input clock.

The decision draws on several inputs:
- two mode pins, which pick one of four configuration modes;
- a per-mode lock-ratio pointer;
- a per-mode manual source bit;
- an optional override pin, whose role is set by a global 3-bit field;
- a presence flag for the input clock.

The block outputs the selected source and the index of the ratio slot in use. It also drives a lock indication, which stays low while the synthesizer re-acquires after any change.

Each mode has its own ratio slot, and that slot has the same index as the mode. If a mode's lock-ratio pointer names its own slot, the mode runs manually and its manual bit picks the source. If the pointer names any other slot, the mode runs automatically. In that case the input clock, while present, drives the dynamic ratio aimed at the pointed-to slot. When the input clock disappears, a short grace period runs, and then the block falls back to the reference clock and the mode's own slot. The override pin, when configured for it, forces the source directly and takes priority over both schemes.

Top module: `ratio_src_sel`

## Requirements
- R1: The two mode pins pass through a two-flip-flop synchronizer. The synchronized value selects mode 0 to 3. A change on the pins reaches the registered outputs on the third clock edge after it is applied.
- R2: Manual mode applies when the active mode's 2-bit lock-ratio pointer (bits [2m+1:2m] of the pointer bus for mode m) equals the mode index. In manual mode, the mode's manual bit selects the source (1 = dynamic, 0 = reference), and the index output equals the mode. The presence flag has no effect.
- R3: Automatic mode applies when the pointer differs from the mode. While the presence flag is high, the source is dynamic and the index output equals the pointer. The manual bit is ignored.
- R4: In automatic mode, once the presence flag has been low long enough, the source is reference and the index output equals the active mode.
- R5: After a loss of the input clock in automatic mode, the dynamic source is kept on the first edge that samples the presence flag low. The switch to reference happens on the second consecutive low edge.
- R6: If the presence flag returns high during the grace period, the pending switch is cancelled and the source stays dynamic. A later loss again needs two consecutive low edges.
- R7: When the global pin-configuration field equals 3'b101, the synchronized override pin selects the source (1 = dynamic, 0 = reference). This overrides both the manual bit and automatic selection, and no grace period applies. Every other code leaves source selection unaffected. The index output is the pointer when the source is dynamic and the mode otherwise.
- R8: The lock output goes low on the edge where the source, the index or the mode changes. It rises again exactly UNLOCK_CYC edges later. It is also held low while a grace period is pending.
- R9: Under synchronous reset the source is reference, the index is 0 and the lock output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference/system clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin_i | input | 2 | Asynchronous mode select pins |
| ovr_pin_i | input | 1 | Asynchronous override pin |
| lock_ptr_i | input | 8 | Per-mode lock-ratio pointers, 2 bits per mode |
| manual_src_i | input | 4 | Per-mode manual source bit (1 = dynamic) |
| pin_cfg_i | input | 3 | Global override-pin function code |
| clkin_present_i | input | 1 | Input clock presence flag, synchronous to clk |
| src_dyn_o | output | 1 | Selected source: 1 = dynamic input-clock ratio, 0 = static reference ratio |
| ratio_idx_o | output | 2 | Index of the ratio slot in use |
| locked_o | output | 1 | Lock indication |

## Verification
The bench keeps GRACE_CYC at its default of 2, so both the first-edge hold and the cancel-and-restart case of the grace period are checked edge by edge. It builds the block with UNLOCK_CYC set to 4. This short recovery window lets each scenario check the falling edge and the exact re-assertion edge of the lock output without long waits. The synchronizer depth stays at 2, which fixes the three-edge latency from pin to output that the latency checks sample against.

// File: rtl/ratio_sel_pkg.sv
package ratio_sel_pkg;
  localparam logic SRC_REF = 1'b0;
  localparam logic SRC_DYN = 1'b1;
  localparam int   MODE_W  = 2;
  localparam int   CFG_W   = 3;
endpackage

// File: rtl/ratio_pin_sync.sv
module ratio_pin_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ratio_src_decide.sv
module ratio_src_decide
  import ratio_sel_pkg::*;
#(
  parameter int          MW           = MODE_W,
  parameter int          CW           = CFG_W,
  parameter logic [CW-1:0] PIN_SRC_CODE = 3'b101,
  parameter int          GRACE_CYC    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MW-1:0]            mode_s_i,
  input  logic                     ovr_s_i,
  input  logic [(1<<MW)*MW-1:0]    lock_ptr_i,
  input  logic [(1<<MW)-1:0]       manual_src_i,
  input  logic [CW-1:0]            pin_cfg_i,
  input  logic                     present_i,
  output logic                     src_q_o,
  output logic [MW-1:0]            idx_q_o,
  output logic                     change_o,
  output logic                     hold_o
);
  localparam int GCNT_W = $clog2(GRACE_CYC + 1);

  logic [MW-1:0]     ptr;
  logic              pin_ctl, auto_en, wanted, leaving;
  logic              src_nxt;
  logic [MW-1:0]     idx_nxt;
  logic [MW-1:0]     mode_q;
  logic [GCNT_W-1:0] g_cnt, g_nxt;

  always_comb begin
    ptr     = lock_ptr_i[int'(mode_s_i)*MW +: MW];
    pin_ctl = (pin_cfg_i == PIN_SRC_CODE);
    auto_en = (ptr != mode_s_i);
    if (pin_ctl)       wanted = ovr_s_i;
    else if (!auto_en) wanted = manual_src_i[mode_s_i];
    else               wanted = present_i;
    leaving = !pin_ctl && auto_en && !present_i && (src_q_o == SRC_DYN);
    hold_o  = 1'b0;
    if (leaving) begin
      if (g_cnt >= GCNT_W'(GRACE_CYC - 1)) begin
        src_nxt = SRC_REF;
        g_nxt   = '0;
      end else begin
        src_nxt = SRC_DYN;
        g_nxt   = g_cnt + 1'b1;
        hold_o  = 1'b1;
      end
    end else begin
      src_nxt = wanted;
      g_nxt   = '0;
    end
    idx_nxt  = (src_nxt == SRC_DYN) ? ptr : mode_s_i;
    change_o = (src_nxt != src_q_o) || (idx_nxt != idx_q_o) || (mode_s_i != mode_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q_o <= SRC_REF;
      idx_q_o <= '0;
      mode_q  <= '0;
      g_cnt   <= '0;
    end else begin
      src_q_o <= src_nxt;
      idx_q_o <= idx_nxt;
      mode_q  <= mode_s_i;
      g_cnt   <= g_nxt;
    end
  end

  // R5
  grace_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (leaving && g_cnt == '0 && GRACE_CYC > 1) |=> src_q_o == SRC_DYN);

  // R4
  static_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (src_q_o == SRC_REF) |-> idx_q_o == mode_q);

  // R7
  pin_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    pin_ctl |=> src_q_o == $past(ovr_s_i));

  // R3
  auto_dyn_chk: assert property (@(posedge clk) disable iff (rst)
    (!pin_ctl && auto_en && present_i) |=> (src_q_o == SRC_DYN) && idx_q_o == $past(ptr));
endmodule

// File: rtl/ratio_lock_timer.sv
module ratio_lock_timer #(
  parameter int UNLOCK_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic change_i,
  input  logic hold_i,
  output logic locked_o
);
  localparam int CNT_W = $clog2(UNLOCK_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= CNT_W'(UNLOCK_CYC);
      locked_o <= 1'b0;
    end else if (change_i || hold_i) begin
      cnt      <= CNT_W'(UNLOCK_CYC);
      locked_o <= 1'b0;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      locked_o <= (cnt <= CNT_W'(1));
    end
  end

  // R8
  unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (change_i || hold_i) |=> !locked_o);

  // R8
  lock_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    locked_o |-> cnt == '0);
endmodule

// File: rtl/ratio_src_sel.sv
module ratio_src_sel
  import ratio_sel_pkg::*;
#(
  parameter int UNLOCK_CYC  = 8,
  parameter int GRACE_CYC   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [MODE_W-1:0]      mode_pin_i,
  input  logic                   ovr_pin_i,
  input  logic [(1<<MODE_W)*MODE_W-1:0] lock_ptr_i,
  input  logic [(1<<MODE_W)-1:0] manual_src_i,
  input  logic [CFG_W-1:0]       pin_cfg_i,
  input  logic                   clkin_present_i,
  output logic                   src_dyn_o,
  output logic [MODE_W-1:0]      ratio_idx_o,
  output logic                   locked_o
);
  logic [MODE_W-1:0] mode_s;
  logic              ovr_s;
  logic              change, hold;

  ratio_pin_sync #(.WIDTH(MODE_W), .STAGES(SYNC_STAGES)) u_mode_sync (
    .clk(clk), .rst(rst), .d_i(mode_pin_i), .q_o(mode_s));

  ratio_pin_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ovr_sync (
    .clk(clk), .rst(rst), .d_i(ovr_pin_i), .q_o(ovr_s));

  ratio_src_decide #(.GRACE_CYC(GRACE_CYC)) u_decide (
    .clk(clk), .rst(rst), .mode_s_i(mode_s), .ovr_s_i(ovr_s),
    .lock_ptr_i(lock_ptr_i), .manual_src_i(manual_src_i),
    .pin_cfg_i(pin_cfg_i), .present_i(clkin_present_i),
    .src_q_o(src_dyn_o), .idx_q_o(ratio_idx_o),
    .change_o(change), .hold_o(hold));

  ratio_lock_timer #(.UNLOCK_CYC(UNLOCK_CYC)) u_lock (
    .clk(clk), .rst(rst), .change_i(change), .hold_i(hold),
    .locked_o(locked_o));
endmodule

// File: tb/ratio_src_sel_bench.sv
module ratio_src_sel_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_pin = 2'd0;
  logic       ovr_pin = 1'b0;
  logic [7:0] lock_ptr = 8'b11_10_01_00;
  logic [3:0] manual = 4'b0000;
  logic [2:0] pin_cfg = 3'b000;
  logic       present = 1'b0;
  logic       src_dyn;
  logic [1:0] idx;
  logic       locked;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ratio_src_sel #(.UNLOCK_CYC(4), .GRACE_CYC(2), .SYNC_STAGES(2)) u_ratio_src_sel (
    .clk(clk), .rst(rst), .mode_pin_i(mode_pin), .ovr_pin_i(ovr_pin),
    .lock_ptr_i(lock_ptr), .manual_src_i(manual), .pin_cfg_i(pin_cfg),
    .clkin_present_i(present), .src_dyn_o(src_dyn), .ratio_idx_o(idx),
    .locked_o(locked));

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int s, input int i, input int l);
    chk({req, " src"}, int'(src_dyn), s);
    chk({req, " idx"}, int'(idx), i);
    if (l >= 0) chk({req, " lock"}, int'(locked), l);
  endtask

  task automatic t_reset;
    tick(1);
    chk_out("R9 reset", 0, 0, 0);
    rst = 1'b0;
    tick(10);
    chk_out("R9 after reset", 0, 0, 1);
  endtask

  task automatic t_manual;
    mode_pin = 2'd2; manual = 4'b0100;
    tick(10);
    chk_out("R2 manual dyn", 1, 2, 1);
    present = 1'b1;
    tick(3);
    chk_out("R2 presence ignored", 1, 2, 1);
    manual = 4'b0000;
    tick(1);
    chk_out("R2 manual ref", 0, 2, 0);
    present = 1'b0;
    tick(10);
    chk_out("R2 settled", 0, 2, 1);
  endtask

  task automatic t_latency;
    manual = 4'b0010;
    tick(1);
    chk_out("R2 mode2 bit clear", 0, 2, 1);
    mode_pin = 2'd1;
    tick(2);
    chk_out("R1 no change before third edge", 0, 2, 1);
    tick(1);
    chk_out("R1 change on third edge", 1, 1, 0);
    tick(3);
    chk("R8 still unlocked", int'(locked), 0);
    tick(1);
    chk("R8 relocked after UNLOCK_CYC", int'(locked), 1);
  endtask

  task automatic t_auto;
    lock_ptr[3:2] = 2'd3; manual = 4'b0000; present = 1'b1;
    tick(10);
    chk_out("R3 auto present", 1, 3, 1);
  endtask

  task automatic t_grace;
    manual = 4'b0010;
    tick(10);
    present = 1'b0;
    tick(1);
    chk_out("R5 first low edge holds", 1, 3, 0);
    tick(1);
    chk_out("R4 switch on second edge", 0, 1, 0);
    tick(10);
    chk_out("R4 static settled, manual ignored", 0, 1, 1);
    present = 1'b1;
    tick(1);
    chk_out("R3 return to dynamic", 1, 3, 0);
  endtask

  task automatic t_cancel;
    tick(10);
    present = 1'b0;
    tick(1);
    chk("R6 pending", int'(src_dyn), 1);
    present = 1'b1;
    tick(1);
    chk("R6 cancelled", int'(src_dyn), 1);
    present = 1'b0;
    tick(1);
    chk("R6 grace restarted", int'(src_dyn), 1);
    tick(1);
    chk_out("R6 switch after restart", 0, 1, 0);
    present = 1'b1;
    tick(10);
  endtask

  task automatic t_pin;
    pin_cfg = 3'b101; ovr_pin = 1'b0;
    tick(4);
    chk_out("R7 pin forces ref", 0, 1, -1);
    ovr_pin = 1'b1;
    tick(4);
    chk_out("R7 pin forces dyn", 1, 3, -1);
    present = 1'b0;
    tick(1);
    chk_out("R7 no grace under pin", 1, 3, -1);
    tick(4);
    chk_out("R7 pin overrides auto", 1, 3, -1);
    pin_cfg = 3'b010;
    tick(4);
    chk_out("R7 other code no effect", 0, 1, -1);
    mode_pin = 2'd3; manual = 4'b0000; lock_ptr[7:6] = 2'd3; pin_cfg = 3'b101;
    tick(10);
    chk_out("R7 pin overrides manual", 1, 3, 1);
    pin_cfg = 3'b111;
    tick(1);
    chk_out("R7 manual again", 0, 3, 0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_manual();
    t_latency();
    t_auto();
    t_grace();
    t_cancel();
    t_pin();
    finish_run();
  end

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end
endmodule